// File: doc/BRIEF.md
# Flow-Control Frame Generator

This block turns the backpressure state carried in each received switch-cell header into a flow-control frame. The frame goes to an outbound control queue as a burst of eight 32-bit words. A header parser presents the five unicast queue backpressure records and the two-bit multicast backpressure field with a one-cycle `cell_valid` strobe. The block keeps the latest of these as a snapshot and decides when a new frame is needed. It then serialises the frame into the control FIFO, but only when that FIFO reports room for a whole frame.

A frame is 32 bytes long, sent most significant byte first within each word. It holds a 2-byte base header, seven 4-byte entries and a 2-byte vertical parity word. Entries 1 to 5 follow unicast queues 0 to 4. Entries 6 and 7 carry low- and high-priority multicast state. Frames are sent only when the backpressure picture changes or when a programmable number of cells has passed. This keeps the control path quiet while conditions are steady.

Top module: `fc_frame_gen`

## Requirements
- R1: After reset `fc_wr` is low and stays low until a cell strobe has been accepted.
- R2: A frame is exactly eight consecutive writes. Byte 0 (word 0 bits [31:24]) is {data_ready, ctrl_ready, type 4'b0110, 1'b0, 1'b0}, with both ready inputs sampled when the frame starts. Byte 1 is the payload length 28. Bytes 2+4e to 5+4e hold entry e (e = 0..6).
- R3: Unicast entry e (e = 0..4) is built from queue e. Its class byte is e. Its control byte has bits [7:6] = 2'b10 (xoff) when the queue's on flag is 1 and 2'b01 (xon) otherwise, bit 5 class wildcard = 0, bit 4 port wildcard = 0, bits [3:1] = 0 and bit 0 = the queue's speed flag. The third byte is {4'b0, dest[11:8]} and the fourth byte is dest[7:0].
- R4: Entry 5 (low-priority multicast) is driven by `mc_bkp[0]` and entry 6 (high-priority multicast) by `mc_bkp[1]`. Each uses the same xon/xoff code as R3, has class byte 5 or 6 respectively, port wildcard = 1, speed = 0 and destination 0.
- R5: Bytes 30 and 31 are the bitwise inverse of the XOR of the fifteen preceding 16-bit halfwords. The XOR of all sixteen halfwords of a frame is therefore 16'hFFFF.
- R6: When a strobe at clock edge k triggers a frame and the FIFO has room, word 0 is written at edge k+2 and word 7 at edge k+9.
- R7: The first strobe after reset triggers a frame. After that, a strobe triggers a frame only if its backpressure fields differ from those of the last frame sent. Repeating identical content produces no write while `refresh_cells` is 0.
- R8: When `refresh_cells` is N (N > 0), the N-th strobe counted from the start of the last frame triggers a frame even if the content is unchanged. The (N-1)-th strobe does not.
- R9: A frame starts only while `fifo_free` is at least 8. Until then the request stays pending, and the frame that is eventually sent carries the most recent snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_valid | input | 1 | One-cycle strobe: backpressure fields below are valid |
| q_dest | input | 60 | Five 12-bit queue backpressure fields, queue 0 in bits [11:0] |
| q_speed | input | 5 | Per-queue speed flag |
| q_on | input | 5 | Per-queue backpressure-on flag |
| mc_bkp | input | 2 | Multicast backpressure, bit 0 low priority, bit 1 high priority |
| data_ready | input | 1 | Data ready bit for the base header |
| ctrl_ready | input | 1 | Control ready bit for the base header |
| refresh_cells | input | 16 | Refresh interval in cells, 0 disables |
| fifo_free | input | 10 | Free word count of the control FIFO |
| fc_wr | output | 1 | Control FIFO write enable |
| fc_wdata | output | 32 | Control FIFO write word |

## Verification
A frame triggered by a strobe at edge k is due with word 0 two edges later and one word per edge after that. The bench counts those edges from the edge it drove the strobe on. It samples each word on the falling edge that follows. If the FIFO was short of room, the frame is due two edges after the edge on which room returns, so the bench counts from that edge. Cases where no frame should appear are checked by watching `fc_wr` on every falling edge over a window longer than a full frame.

// File: rtl/fc_frame_pkg.sv
package fc_frame_pkg;
  localparam int NQ       = 5;
  localparam int DEST_W   = 12;
  localparam int NENT     = NQ + 2;
  localparam int NHALF    = 2 + 2 * NENT;     // halfwords before and incl. parity
  localparam int NWORDS   = NHALF / 2;
  localparam int WORD_W   = 32;
  localparam logic [3:0] FC_TYPE = 4'h6;
  localparam logic [7:0] FC_LEN  = 8'(4 * NENT);
  localparam logic [1:0] CODE_XON  = 2'b01;
  localparam logic [1:0] CODE_XOFF = 2'b10;

  typedef struct packed {
    logic [NQ-1:0][DEST_W-1:0] dest;
    logic [NQ-1:0]             spd;
    logic [NQ-1:0]             on;
    logic [1:0]                mc;
  } bkp_t;

  function automatic logic [31:0] build_entry(input int e, input bkp_t b);
    logic [7:0] cls, ctl, hi, lo;
    cls = 8'(e);
    if (e < NQ) begin
      ctl = {(b.on[e] ? CODE_XOFF : CODE_XON), 1'b0, 1'b0, 3'b000, b.spd[e]};
      hi  = {4'b0000, b.dest[e][11:8]};
      lo  = b.dest[e][7:0];
    end else begin
      ctl = {(b.mc[e-NQ] ? CODE_XOFF : CODE_XON), 1'b0, 1'b1, 4'b0000};
      hi  = 8'h00;
      lo  = 8'h00;
    end
    return {cls, ctl, hi, lo};
  endfunction
endpackage

// File: rtl/fc_trigger.sv
module fc_trigger
  import fc_frame_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_valid,
  input  bkp_t             bkp_in,
  input  logic [CNT_W-1:0] refresh_cells,
  input  logic             start,
  output bkp_t             snap,
  output logic             pending
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  bkp_t             last_sent;
  logic             sent_any;
  logic [CNT_W-1:0] cell_cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             trig;

  assign cnt_inc = (cell_cnt == CNT_MAX) ? cell_cnt : cell_cnt + 1'b1;
  assign trig = !sent_any || (bkp_in != last_sent) ||
                ((refresh_cells != '0) && (cnt_inc >= refresh_cells));

  always_ff @(posedge clk) begin
    if (rst) begin
      snap      <= '0;
      last_sent <= '0;
      sent_any  <= 1'b0;
      cell_cnt  <= '0;
      pending   <= 1'b0;
    end else begin
      if (start) begin
        last_sent <= snap;
        sent_any  <= 1'b1;
      end
      if (cell_valid) snap <= bkp_in;
      if (start)           cell_cnt <= cell_valid ? CNT_W'(1) : '0;
      else if (cell_valid) cell_cnt <= cnt_inc;
      if (cell_valid && trig) pending <= 1'b1;
      else if (start)         pending <= 1'b0;
    end
  end

  // R7: a request only ever appears in response to a cell strobe
  a_r7_pending_from_cell: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(cell_valid));
  // R9: a held request stays held until a frame actually starts
  a_r9_pending_held: assert property (@(posedge clk) disable iff (rst)
    (pending && !start) |=> pending);
endmodule

// File: rtl/fc_frame_build.sv
module fc_frame_build
  import fc_frame_pkg::*;
(
  input  bkp_t                          bkp,
  input  logic                          rdy_data,
  input  logic                          rdy_ctrl,
  output logic [NWORDS-1:0][WORD_W-1:0] words
);
  logic [NHALF-1:0][15:0] hw;
  logic [15:0]            acc;

  always_comb begin
    hw[0] = {rdy_data, rdy_ctrl, FC_TYPE, 1'b0, 1'b0, FC_LEN};
    for (int e = 0; e < NENT; e++) begin
      logic [31:0] ent;
      ent = build_entry(e, bkp);
      hw[1 + 2*e] = ent[31:16];
      hw[2 + 2*e] = ent[15:0];
    end
    acc = '0;
    for (int h = 0; h < NHALF-1; h++) acc = acc ^ hw[h];
    hw[NHALF-1] = ~acc;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_pack
    assign words[w] = {hw[2*w], hw[2*w+1]};
  end
endmodule

// File: rtl/fc_sender.sv
module fc_sender
  import fc_frame_pkg::*;
#(
  parameter int FREE_W = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pending,
  input  bkp_t                          snap,
  input  logic                          data_ready,
  input  logic                          ctrl_ready,
  input  logic [FREE_W-1:0]             fifo_free,
  input  logic [NWORDS-1:0][WORD_W-1:0] words,
  output logic                          start,
  output bkp_t                          frozen,
  output logic                          rdy_data,
  output logic                          rdy_ctrl,
  output logic                          wr,
  output logic [WORD_W-1:0]             wdata
);
  localparam int IDX_W = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;
  logic             room;

  assign room  = (32'(fifo_free) >= NWORDS);
  assign start = pending && !busy && room;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      wr       <= 1'b0;
      wdata    <= '0;
      frozen   <= '0;
      rdy_data <= 1'b0;
      rdy_ctrl <= 1'b0;
    end else begin
      wr <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        idx      <= '0;
        frozen   <= snap;
        rdy_data <= data_ready;
        rdy_ctrl <= ctrl_ready;
      end else if (busy) begin
        wr    <= 1'b1;
        wdata <= words[idx];
        idx   <= idx + 1'b1;
        if (idx == LAST) busy <= 1'b0;
      end
    end
  end

  // checker state: length of the current write run and its halfword XOR
  logic [IDX_W:0] run_q;
  logic [15:0]    par_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      par_q <= '0;
    end else if (wr) begin
      run_q <= run_q + 1'b1;
      par_q <= par_q ^ wdata[31:16] ^ wdata[15:0];
    end else begin
      run_q <= '0;
      par_q <= '0;
    end
  end

  // R2: every write run is one whole frame
  a_r2_burst_len: assert property (@(posedge clk) disable iff (rst)
    $fell(wr) |-> (32'(run_q) == NWORDS));
  a_r2_burst_cap: assert property (@(posedge clk) disable iff (rst)
    wr |-> (32'(run_q) < NWORDS));
  // R2: the first word of a frame carries the flow-control type and length
  a_r2_first_header: assert property (@(posedge clk) disable iff (rst)
    (wr && !$past(wr)) |-> (wdata[29:26] == FC_TYPE && wdata[23:16] == FC_LEN));
  // R5: the halfwords of a finished frame XOR to all ones
  a_r5_odd_parity: assert property (@(posedge clk) disable iff (rst)
    $fell(wr) |-> (par_q == 16'hFFFF));
  // R9: a frame never begins without room for all its words
  a_r9_room_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (32'($past(fifo_free)) >= NWORDS));
endmodule

// File: rtl/fc_frame_gen.sv
module fc_frame_gen
  import fc_frame_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FREE_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cell_valid,
  input  logic [NQ*DEST_W-1:0] q_dest,
  input  logic [NQ-1:0]        q_speed,
  input  logic [NQ-1:0]        q_on,
  input  logic [1:0]           mc_bkp,
  input  logic                 data_ready,
  input  logic                 ctrl_ready,
  input  logic [CNT_W-1:0]     refresh_cells,
  input  logic [FREE_W-1:0]    fifo_free,
  output logic                 fc_wr,
  output logic [WORD_W-1:0]    fc_wdata
);
  bkp_t                          bkp_in, snap, frozen;
  logic                          pending, start, rdy_data, rdy_ctrl;
  logic [NWORDS-1:0][WORD_W-1:0] words;

  assign bkp_in.dest = q_dest;
  assign bkp_in.spd  = q_speed;
  assign bkp_in.on   = q_on;
  assign bkp_in.mc   = mc_bkp;

  fc_trigger #(.CNT_W(CNT_W)) u_trig (
    .clk(clk), .rst(rst), .cell_valid(cell_valid), .bkp_in(bkp_in),
    .refresh_cells(refresh_cells), .start(start), .snap(snap), .pending(pending)
  );

  fc_frame_build u_build (
    .bkp(frozen), .rdy_data(rdy_data), .rdy_ctrl(rdy_ctrl), .words(words)
  );

  fc_sender #(.FREE_W(FREE_W)) u_send (
    .clk(clk), .rst(rst), .pending(pending), .snap(snap),
    .data_ready(data_ready), .ctrl_ready(ctrl_ready), .fifo_free(fifo_free),
    .words(words), .start(start), .frozen(frozen), .rdy_data(rdy_data),
    .rdy_ctrl(rdy_ctrl), .wr(fc_wr), .wdata(fc_wdata)
  );
endmodule

// File: tb/fc_frame_gen_bench.sv
module fc_frame_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_valid = 1'b0;
  logic [59:0] q_dest;
  logic [4:0]  q_speed = '0, q_on = '0;
  logic [1:0]  mc_bkp = '0;
  logic        data_ready = 1'b1, ctrl_ready = 1'b0;
  logic [15:0] refresh_cells = '0;
  logic [9:0]  fifo_free = 10'd64;
  logic        fc_wr;
  logic [31:0] fc_wdata;

  logic [11:0] dq [5];
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  fc_frame_gen u_fc_frame_gen (
    .clk(clk), .rst(rst), .cell_valid(cell_valid), .q_dest(q_dest),
    .q_speed(q_speed), .q_on(q_on), .mc_bkp(mc_bkp), .data_ready(data_ready),
    .ctrl_ready(ctrl_ready), .refresh_cells(refresh_cells),
    .fifo_free(fifo_free), .fc_wr(fc_wr), .fc_wdata(fc_wdata)
  );

  assign q_dest = {dq[4], dq[3], dq[2], dq[1], dq[0]};

  function automatic logic [31:0] exp_word(int w);
    logic [7:0]  b [32];
    logic [15:0] acc;
    b[0] = {data_ready, ctrl_ready, 4'b0110, 2'b00};
    b[1] = 8'd28;
    for (int e = 0; e < 7; e++) begin
      logic off;
      off = (e < 5) ? q_on[e] : mc_bkp[e-5];
      b[2+4*e] = 8'(e);
      b[3+4*e] = {(off ? 2'b10 : 2'b01), 1'b0, (e >= 5), 3'b000,
                  (e < 5) ? q_speed[e] : 1'b0};
      b[4+4*e] = (e < 5) ? {4'h0, dq[e][11:8]} : 8'h00;
      b[5+4*e] = (e < 5) ? dq[e][7:0] : 8'h00;
    end
    acc = '0;
    for (int h = 0; h < 15; h++) acc = acc ^ {b[2*h], b[2*h+1]};
    b[30] = ~acc[15:8];
    b[31] = ~acc[7:0];
    return {b[4*w], b[4*w+1], b[4*w+2], b[4*w+3]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_cell();
    @(negedge clk);
    cell_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cell_valid = 1'b0;
  endtask

  // called on the negedge following the triggering edge
  task automatic expect_frame(input string req);
    @(posedge clk);
    @(posedge clk);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      check(fc_wr === 1'b1 && fc_wdata === exp_word(w), req,
            {fc_wr, fc_wdata[30:0]}, exp_word(w));
    end
    @(negedge clk);
    check(fc_wr === 1'b0, {req, " end of burst"}, {31'b0, fc_wr}, 32'd0);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fc_wr !== 1'b0) seen = 1'b1;
    end
    check(!seen, req, {31'b0, seen}, 32'd0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 5; i++) dq[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_quiet(12, "R1 idle after reset");
  endtask

  task automatic t_first();
    dq[0] = 12'hA5C; dq[1] = 12'h3F0; dq[2] = 12'h001;
    dq[3] = 12'hFFF; dq[4] = 12'h800;
    q_speed = 5'b10110; q_on = 5'b01101; mc_bkp = 2'b01;
    send_cell();
    expect_frame("R2 R3 R4 R5 R6 R7 first frame");
  endtask

  task automatic t_same();
    send_cell();
    expect_quiet(14, "R7 unchanged content ignored");
  endtask

  task automatic t_change();
    mc_bkp = 2'b10;
    ctrl_ready = 1'b1; data_ready = 1'b0;
    send_cell();
    expect_frame("R4 R7 multicast change frame");
  endtask

  task automatic t_refresh();
    refresh_cells = 16'd3;
    send_cell();
    send_cell();
    expect_quiet(12, "R8 no frame before refresh count");
    send_cell();
    expect_frame("R8 refresh frame");
    refresh_cells = 16'd0;
  endtask

  task automatic t_defer();
    fifo_free = 10'd7;
    dq[2] = 12'h7E3; q_on = 5'b10010;
    send_cell();
    expect_quiet(14, "R9 deferred while FIFO short");
    dq[3] = 12'h024; q_speed = 5'b00001; mc_bkp = 2'b11;
    send_cell();
    expect_quiet(6, "R9 still deferred");
    fifo_free = 10'd8;
    expect_frame("R9 latest snapshot sent");
  endtask

  initial begin
    t_reset();
    t_first();
    t_same();
    t_change();
    t_refresh();
    t_defer();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule